// File: doc/BRIEF.md
# Two-Slot Split-Function Processor Core

This block is a compact in-order core that fetches one 32-bit instruction line per clock and executes the two 16-bit instructions in that line together. The two instructions run in two issue slots, and each slot has its own fixed set of operations.

- **Slot A** takes the upper half of the line. It handles arithmetic, compare and the conditional branch. It also owns the line counter that addresses the instruction memory.
- **Slot B** takes the lower half of the line. It handles every data-memory access: a plain load, a load and a store that add a small offset to a base register inside one instruction, and a register move.

Both slots read and write the same eight 32-bit registers.

There is no interlock, forwarding or queue. Register reads in a line always see the values committed by earlier lines. The program schedule must keep dependent operations in different lines, and it fills empty slots with a move of a register onto itself.

Both memories are read combinationally, so each line completes in the cycle it is fetched. A store is written at the clock edge that ends the line. A debug select input reads out any register combinationally.

Top module: `dualslot_core`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, the line address is 0, all eight registers read 0 and the compare flag is clear.
- R2: Bits 31:16 of a line are the slot A instruction and bits 15:0 are the slot B instruction, and both take effect in the same cycle. Within each half, the opcode is [15:12], field X is [11:9], field Y is [8:6], field Z is [5:3], the immediate is [5:0] and the branch target is [11:0].
- R3: Slot A operations:
  - opcode 0: X = Y.
  - opcode 1: X = Y shifted left by imm[4:0].
  - opcode 2: X = Y + Z.
  - opcode 5: X = low 32 bits of X times Y.
- R4: Slot A opcode 3 sets the flag to (X <= Y) as a signed comparison. Slot A opcode 4 loads the line address with the 12-bit target when the flag is set, with no delay slot. Every other line advances the address by one, wrapping from 4095 to 0.
- R5: Slot B operations use word addresses:
  - opcode 1: X = M[Y].
  - opcode 2: X = M[Y + imm], with imm zero-extended.
  - opcode 3: M[Y + imm] = X, and no register changes.
  - opcode 0: X = Y.
  - The data write strobe rises only for opcode 3.
- R6: A move of a register onto itself has no effect in either slot. Undefined opcodes (slot A 6 to 15, slot B 4 to 15) change no register and no memory word, and the line address still advances.
- R7: Both slots read register values as they stood at the start of the cycle, so two moves paired in one line swap two registers.
- R8: When both slots write the same register in one cycle, the slot B value is kept.
- R9: The slot B instruction in a line whose branch is taken still executes.
- R10: dbg_val shows the register selected by dbg_sel without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 12 | Instruction line address |
| imem_rdata | input | 32 | Instruction line, combinational read |
| dmem_addr | output | 32 | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data, combinational read |
| dbg_sel | input | 3 | Register select for debug view |
| dbg_val | output | 32 | Selected register value |

## Verification
The register file has two write ports, so the interesting same-cycle cases are those where both slots act on shared state in one line:

- both slots write the same register;
- each slot reads a register that the other slot overwrites in that line;
- slot A takes a branch while slot B performs a load.

Directed programs place these pairs in a single line. The bench then judges the outcome from the debug register view and the next line address: slot B must win, a swap must appear, and the load must land while the address jumps. Signed versus unsigned compare, taken and not-taken branches, and the address wrap are checked in separate programs.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SLOT_W  = 16;
  localparam int unsigned LINE_W  = 2 * SLOT_W;
  localparam int unsigned NREGS   = 8;
  localparam int unsigned RIDX_W  = $clog2(NREGS);
  localparam int unsigned IMM_W   = 6;
  localparam int unsigned TGT_W   = 12;
  localparam int unsigned SHAMT_W = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  // slot A operation codes
  typedef enum logic [3:0] {
    OPA_MOV = 4'd0,
    OPA_LSL = 4'd1,
    OPA_ADD = 4'd2,
    OPA_CMP = 4'd3,
    OPA_BLE = 4'd4,
    OPA_MUL = 4'd5
  } opa_e;

  // slot B operation codes
  typedef enum logic [3:0] {
    OPB_MOV = 4'd0,
    OPB_LDR = 4'd1,
    OPB_LDO = 4'd2,
    OPB_STO = 4'd3
  } opb_e;

  // common field layout of one 16-bit slot instruction
  typedef struct packed {
    logic [3:0] op;
    ridx_t      fx;
    ridx_t      fy;
    ridx_t      fz;
    logic [2:0] ft;
  } slot_t;

  function automatic logic [IMM_W-1:0] slot_imm(input slot_t s);
    return {s.fz, s.ft};
  endfunction

  function automatic logic [TGT_W-1:0] slot_target(input slot_t s);
    return {s.fx, s.fy, s.fz, s.ft};
  endfunction

  function automatic word_t shift_up(input word_t v, input logic [SHAMT_W-1:0] n);
    return v << n;
  endfunction

  function automatic logic signed_le(input word_t a, input word_t b);
    return $signed(a) <= $signed(b);
  endfunction

  function automatic word_t mul_low(input word_t a, input word_t b);
    logic [2*WORD_W-1:0] full;
    full = a * b;
    return full[WORD_W-1:0];
  endfunction

  function automatic word_t offset_addr(input word_t base, input logic [IMM_W-1:0] off);
    return base + {{(WORD_W-IMM_W){1'b0}}, off};
  endfunction
endpackage

// File: rtl/dsc_regfile.sv
module dsc_regfile
  import dsc_pkg::*;
#(
  parameter int unsigned NRD = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ridx_t rd_idx [NRD],
  output word_t rd_val [NRD],
  input  logic  wa_en,
  input  ridx_t wa_idx,
  input  word_t wa_val,
  input  logic  wb_en,
  input  ridx_t wb_idx,
  input  word_t wb_val
);
  word_t store [NREGS];

  // port B is applied last so it wins a same-index collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREGS); i++) store[i] <= '0;
    end else begin
      if (wa_en) store[wa_idx] <= wa_val;
      if (wb_en) store[wb_idx] <= wb_val;
    end
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rd_val[g] = store[rd_idx[g]];
  end
endmodule

// File: rtl/dsc_slot_a.sv
module dsc_slot_a
  import dsc_pkg::*;
#(
  parameter int unsigned PC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] instr,
  input  word_t             opnd0,
  input  word_t             opnd1,
  output ridx_t             rs0_idx,
  output ridx_t             rs1_idx,
  output logic              wr_en,
  output ridx_t             wr_idx,
  output word_t             wr_val,
  output logic              is_cmp,
  output logic              br_taken,
  output logic              flag,
  output logic [PC_W-1:0]   pc
);
  slot_t               s;
  logic [IMM_W-1:0]    imm;
  logic [SHAMT_W-1:0]  shamt;
  logic [TGT_W-1:0]    target;
  logic                is_add;

  assign s      = slot_t'(instr);
  assign imm    = slot_imm(s);
  assign shamt  = imm[SHAMT_W-1:0];
  assign target = slot_target(s);
  assign is_add = (s.op == OPA_ADD);

  // add reads Y and Z; every other operation reads X and Y
  assign rs0_idx = is_add ? s.fy : s.fx;
  assign rs1_idx = is_add ? s.fz : s.fy;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = s.fx;
    wr_val   = opnd1;
    is_cmp   = 1'b0;
    br_taken = 1'b0;
    case (s.op)
      OPA_MOV: begin wr_en = 1'b1; wr_val = opnd1; end
      OPA_LSL: begin wr_en = 1'b1; wr_val = shift_up(opnd1, shamt); end
      OPA_ADD: begin wr_en = 1'b1; wr_val = opnd0 + opnd1; end
      OPA_CMP: is_cmp = 1'b1;
      OPA_BLE: br_taken = flag;
      OPA_MUL: begin wr_en = 1'b1; wr_val = mul_low(opnd0, opnd1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (is_cmp) flag <= signed_le(opnd0, opnd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= '0;
    else if (br_taken) pc <= PC_W'(target);
    else               pc <= pc + 1'b1;
  end
endmodule

// File: rtl/dsc_slot_b.sv
module dsc_slot_b
  import dsc_pkg::*;
(
  input  logic [SLOT_W-1:0] instr,
  input  word_t             base_val,
  input  word_t             data_val,
  input  word_t             mem_rdata,
  output ridx_t             base_idx,
  output ridx_t             data_idx,
  output logic              wr_en,
  output ridx_t             wr_idx,
  output word_t             wr_val,
  output word_t             mem_addr,
  output word_t             mem_wdata,
  output logic              mem_we
);
  slot_t s;

  assign s         = slot_t'(instr);
  assign base_idx  = s.fy;
  assign data_idx  = s.fx;
  assign mem_wdata = data_val;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = s.fx;
    wr_val   = base_val;
    mem_addr = base_val;
    mem_we   = 1'b0;
    case (s.op)
      OPB_MOV: wr_en = 1'b1;
      OPB_LDR: begin wr_en = 1'b1; wr_val = mem_rdata; end
      OPB_LDO: begin
        mem_addr = offset_addr(base_val, slot_imm(s));
        wr_en    = 1'b1;
        wr_val   = mem_rdata;
      end
      OPB_STO: begin
        mem_addr = offset_addr(base_val, slot_imm(s));
        mem_we   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dualslot_core.sv
module dualslot_core
  import dsc_pkg::*;
#(
  parameter int unsigned PC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [LINE_W-1:0]  imem_rdata,
  output logic [WORD_W-1:0]  dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [WORD_W-1:0]  dmem_rdata,
  input  logic [RIDX_W-1:0]  dbg_sel,
  output logic [WORD_W-1:0]  dbg_val
);
  localparam int unsigned NRD    = 5;
  localparam int unsigned P_A0   = 0;
  localparam int unsigned P_A1   = 1;
  localparam int unsigned P_BASE = 2;
  localparam int unsigned P_DATA = 3;
  localparam int unsigned P_DBG  = 4;

  logic [SLOT_W-1:0] a_instr, b_instr;
  assign a_instr = imem_rdata[LINE_W-1:SLOT_W];
  assign b_instr = imem_rdata[SLOT_W-1:0];

  ridx_t rf_idx [NRD];
  word_t rf_val [NRD];

  // named internal events
  logic  a_wr_en, b_wr_en, a_is_cmp, br_taken, cmp_flag;
  ridx_t a_wr_idx, b_wr_idx;
  word_t a_wr_val, b_wr_val;
  ridx_t a_rs0, a_rs1, b_base, b_data;

  dsc_regfile #(.NRD(NRD)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rf_idx),
    .rd_val (rf_val),
    .wa_en  (a_wr_en),
    .wa_idx (a_wr_idx),
    .wa_val (a_wr_val),
    .wb_en  (b_wr_en),
    .wb_idx (b_wr_idx),
    .wb_val (b_wr_val)
  );

  assign rf_idx[P_A0]   = a_rs0;
  assign rf_idx[P_A1]   = a_rs1;
  assign rf_idx[P_BASE] = b_base;
  assign rf_idx[P_DATA] = b_data;
  assign rf_idx[P_DBG]  = dbg_sel;
  assign dbg_val        = rf_val[P_DBG];

  dsc_slot_a #(.PC_W(PC_W)) u_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (a_instr),
    .opnd0    (rf_val[P_A0]),
    .opnd1    (rf_val[P_A1]),
    .rs0_idx  (a_rs0),
    .rs1_idx  (a_rs1),
    .wr_en    (a_wr_en),
    .wr_idx   (a_wr_idx),
    .wr_val   (a_wr_val),
    .is_cmp   (a_is_cmp),
    .br_taken (br_taken),
    .flag     (cmp_flag),
    .pc       (imem_addr)
  );

  dsc_slot_b u_b (
    .instr     (b_instr),
    .base_val  (rf_val[P_BASE]),
    .data_val  (rf_val[P_DATA]),
    .mem_rdata (dmem_rdata),
    .base_idx  (b_base),
    .data_idx  (b_data),
    .wr_en     (b_wr_en),
    .wr_idx    (b_wr_idx),
    .wr_val    (b_wr_val),
    .mem_addr  (dmem_addr),
    .mem_wdata (dmem_wdata),
    .mem_we    (dmem_we)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
#(
  parameter int unsigned PC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   imem_addr,
  input logic [LINE_W-1:0] imem_rdata,
  input logic              br_taken,
  input logic              dmem_we,
  input logic              b_wr_en,
  input logic              a_is_cmp,
  input logic              cmp_flag
);
  // R1: reset holds the line address at zero
  assert_reset_addr_R1: assert property (@(posedge clk)
    !rst_n |=> imem_addr == '0);

  // R4: sequential advance when no branch is taken
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> imem_addr == $past(imem_addr) + 1'b1);

  // R4: taken branch lands on the target field of the slot A half
  assert_branch_land_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> imem_addr == PC_W'($past(imem_rdata[SLOT_W +: TGT_W])));

  // R4: only a compare may change the flag
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_is_cmp |=> $stable(cmp_flag));

  // R5: a store never writes a register from slot B
  assert_store_no_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !b_wr_en);
endmodule

bind dualslot_core dsc_checker #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .br_taken   (br_taken),
  .dmem_we    (dmem_we),
  .b_wr_en    (b_wr_en),
  .a_is_cmp   (a_is_cmp),
  .cmp_flag   (cmp_flag)
);

// File: tb/dualslot_core_test.sv
`timescale 1ns/1ps
module dualslot_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [11:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata, dbg_val;
  logic        dmem_we;
  logic [2:0]  dbg_sel = 3'd0;

  logic [31:0] imem  [64];
  logic [31:0] dmem  [64];
  logic [31:0] dinit [64];
  int n_checks = 0;
  int n_fail   = 0;
  int we_count = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dualslot_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .dbg_sel    (dbg_sel),
    .dbg_val    (dbg_val)
  );

  assign imem_rdata = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) dmem[k] <= dinit[k];
    end else if (dmem_we) begin
      dmem[dmem_addr[5:0]] <= dmem_wdata;
      we_count <= we_count + 1;
    end
  end

  function automatic logic [15:0] ins(input int op, input int x, input int y, input int imm);
    return {op[3:0], x[2:0], y[2:0], imm[5:0]};
  endfunction

  function automatic logic [15:0] ble(input int tgt);
    return {4'd4, tgt[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int r, input logic [31:0] exp);
    dbg_sel = r[2:0];
    #1;
    chk(tag, dbg_val, exp);
  endtask

  task automatic clear_all();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 64; k++) begin
      imem[k]  = 32'h0;
      dinit[k] = 32'h0;
    end
  endtask

  task automatic go(input int n);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_all();
    @(posedge clk);
    @(negedge clk);
    chk("R1 address in reset", {20'h0, imem_addr}, 32'h0);
    for (int r = 0; r < 8; r++) chk_reg("R1 register zero in reset", r, 32'h0);
  endtask

  task automatic t_arith();
    clear_all();
    dinit[1] = 32'd5; dinit[2] = 32'd7; dinit[3] = 32'hFFFF_FFFD; dinit[5] = 32'h55;
    imem[0] = {ins(0,0,0,0), ins(2,1,0,1)};
    imem[1] = {ins(0,0,0,0), ins(2,2,0,2)};
    imem[2] = {ins(2,3,1,2<<3), ins(2,4,0,3)};
    imem[3] = {ins(1,5,3,4), ins(1,6,1,0)};
    imem[4] = {ins(5,4,2,0), ins(0,0,0,0)};
    go(5);
    chk("R2 five lines advanced", {20'h0, imem_addr}, 32'd5);
    chk_reg("R3 add", 3, 32'd12);
    chk_reg("R3 shift left by 4", 5, 32'd192);
    chk_reg("R3 multiply low word", 4, 32'hFFFF_FFEB);
    chk_reg("R5 plain load via base", 6, 32'h55);
    chk_reg("R10 debug view of loaded r1", 1, 32'd5);
  endtask

  task automatic t_store();
    int w0;
    clear_all();
    dinit[1] = 32'd5;
    dinit[10] = 32'hAAAA_0000;
    imem[0] = {ins(0,0,0,0), ins(2,1,0,1)};
    imem[1] = {ins(0,2,1,0), ins(3,1,1,10)};
    w0 = we_count;
    go(3);
    chk("R5 stored word at base plus offset", dmem[15], 32'd5);
    chk("R5 base-only word untouched", dmem[10], 32'hAAAA_0000);
    chk("R5 one write strobe", we_count - w0, 32'd1);
    chk_reg("R2 slot A move in store line", 2, 32'd5);
  endtask

  task automatic t_branch();
    clear_all();
    dinit[1] = 32'd5; dinit[2] = 32'hFFFF_FFFD;
    imem[0] = {ins(0,0,0,0), ins(2,1,0,1)};
    imem[1] = {ins(0,0,0,0), ins(2,2,0,2)};
    imem[2] = {ins(3,2,1,0), ins(0,0,0,0)};
    imem[3] = {ble(10),      ins(2,3,0,1)};
    imem[4] = {ins(0,4,1,0), ins(0,0,0,0)};
    go(4);
    chk("R4 signed compare taken branch", {20'h0, imem_addr}, 32'd10);
    @(negedge clk);
    chk("R4 advance after target", {20'h0, imem_addr}, 32'd11);
    chk_reg("R9 slot B in branch line executed", 3, 32'd5);
    chk_reg("R4 no delay slot, line 4 skipped", 4, 32'd0);

    clear_all();
    dinit[1] = 32'd5; dinit[2] = 32'hFFFF_FFFD;
    imem[0] = {ins(0,0,0,0), ins(2,1,0,1)};
    imem[1] = {ins(0,0,0,0), ins(2,2,0,2)};
    imem[2] = {ins(3,1,2,0), ins(0,0,0,0)};
    imem[3] = {ble(20),      ins(0,0,0,0)};
    go(4);
    chk("R4 not taken when greater", {20'h0, imem_addr}, 32'd4);

    clear_all();
    dinit[1] = 32'd5;
    imem[0] = {ins(0,0,0,0), ins(2,1,0,1)};
    imem[2] = {ins(3,1,1,0), ins(0,0,0,0)};
    imem[3] = {ble(7),       ins(0,0,0,0)};
    go(4);
    chk("R4 taken on equal", {20'h0, imem_addr}, 32'd7);
  endtask

  task automatic t_pair();
    clear_all();
    dinit[1] = 32'd5; dinit[2] = 32'd7;
    imem[0] = {ins(0,0,0,0), ins(2,1,0,1)};
    imem[1] = {ins(0,0,0,0), ins(2,2,0,2)};
    imem[2] = {ins(0,1,2,0), ins(0,2,1,0)};
    imem[3] = {ins(0,3,1,0), ins(0,3,2,0)};
    go(5);
    chk_reg("R7 swap r1", 1, 32'd7);
    chk_reg("R7 swap r2", 2, 32'd5);
    chk_reg("R8 slot B wins collision", 3, 32'd5);
  endtask

  task automatic t_nop();
    int w0;
    clear_all();
    dinit[1] = 32'd5;
    imem[0] = {ins(0,0,0,0),  ins(2,1,0,1)};
    imem[1] = {ins(9,1,1,3),  ins(7,1,0,1)};
    imem[2] = {ins(0,1,1,0),  ins(0,2,2,0)};
    imem[3] = {ins(15,2,1,0), ins(15,1,2,5)};
    w0 = we_count;
    go(4);
    chk("R6 address advances over undefined", {20'h0, imem_addr}, 32'd4);
    chk("R6 no memory write", we_count - w0, 32'd0);
    chk_reg("R6 r1 unchanged", 1, 32'd5);
    chk_reg("R6 r2 unchanged", 2, 32'd0);
  endtask

  task automatic t_wrap();
    clear_all();
    go(4095);
    chk("R4 address at top", {20'h0, imem_addr}, 32'd4095);
    @(negedge clk);
    chk("R4 address wraps to zero", {20'h0, imem_addr}, 32'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset();
    t_arith();
    t_store();
    t_branch();
    t_pair();
    t_nop();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule